// File: doc/BRIEF.md
# Split-Access Data Memory Port

This block is the data-memory side of a four-stage in-order pipeline. In the execute stage it adds a base register to an offset to form an effective address. It then issues a request to a word-wide data bus that uses request, grant and response signals. The returned data is completed in the writeback stage as a register-file write. Byte, halfword and word loads and stores are supported. Loads are sign or zero extended.

An access that does not fit inside one aligned 32-bit word is split into two bus transactions. This covers a word at a non-multiple-of-four address, and a halfword starting at the last byte of a word. The first transaction goes to the lower word and the second goes to the following word. Each transaction carries only its own share of byte enables. For a load, the two responses are stitched back into byte order before extension.

The pipeline must hold the execute-stage operands steady while `stall_o` is high. The block raises `stall_o` in three cases:
- a request is waiting for grant;
- the second half of a split access has not been granted;
- the writeback stage is still waiting for a response.

Top module: `lsu_split_unit`

## Requirements
- R1: Every bus request carries a word-aligned address (bits 1:0 zero) equal to the effective address (base plus offset, modulo 2^32) with its low two bits cleared. Its byte enables select lanes offset..offset+size-1, where a byte is 1 lane, a halfword 2 and a word 4, and bit k of the enables maps to data bits 8k+7:8k.
- R2: A word access whose address has bits 1:0 not equal to 0 is performed as two transactions. The first goes to the lower word address with enables for the lanes from the offset upward. The second goes to the lower word address plus 4 with enables for the remaining low lanes.
- R3: A halfword at offset 3 is split into two transactions, enables 4'b1000 then 4'b0001. Halfwords at offsets 0, 1 and 2 and all bytes use one transaction.
- R4: `stall_o` is high in every cycle in which the access in execute has not yet had its final request granted. With zero grant wait, an aligned access stalls 0 cycles and a split access stalls 1 cycle.
- R5: Once raised, a request stays asserted with unchanged address and enables until granted. The second transaction of a split access is requested only after the first is granted.
- R6: Store write data is the operand rotated left by 8 times the byte offset, for both transactions, so each enabled lane holds the correct byte.
- R7: For a split load, bytes from the first response (lower word) and the second response (next word) are combined in address order.
- R8: Byte and halfword loads are sign extended when the unsigned input is 0 and zero extended when it is 1. Word loads are returned unchanged.
- R9: `wb_valid_o` pulses for exactly one cycle, in the cycle that the final response of a load arrives, and never for stores. While writeback waits for a response, `stall_o` is high (response latency L adds L-1 stall cycles after the execute phase).
- R10: While `rst` is high, `dbus_req_o`, `stall_o` and `wb_valid_o` are low, even when an access is offered.
- R11: A new access is not requested while the writeback stage still waits for a response that does not arrive in that same cycle. When that response arrives, the next request may go out in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid_i | input | 1 | A memory access is present in the execute stage |
| ex_we_i | input | 1 | 1 for store, 0 for load |
| ex_size_i | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word) |
| ex_unsigned_i | input | 1 | Zero-extend byte/halfword loads |
| ex_base_i | input | 32 | Base register operand |
| ex_offset_i | input | 32 | Offset added to the base |
| ex_wdata_i | input | 32 | Store operand, right-justified |
| stall_o | output | 1 | Pipeline stall |
| dbus_req_o | output | 1 | Bus request |
| dbus_we_o | output | 1 | Bus write enable |
| dbus_addr_o | output | 32 | Word-aligned bus address |
| dbus_be_o | output | 4 | Bus byte enables |
| dbus_wdata_o | output | 32 | Bus write data |
| dbus_gnt_i | input | 1 | Bus grant for the current request |
| dbus_rvalid_i | input | 1 | Bus response valid (in request order) |
| dbus_rdata_i | input | 32 | Bus response read data |
| wb_valid_o | output | 1 | Load result valid for the register file |
| wb_data_o | output | 32 | Extended load result |

## Verification
The hardest state to reach from the ports is the collision of two accesses in flight. In that state the writeback stage still waits for the previous response while the next access already sits in execute. The bench builds it by having the bus model answer with two cycles of latency and offering a second load directly behind the first. It checks that no request leaks out in the waiting cycle and that the request follows in the cycle the response lands. Split accesses are also run with grant waits on either half, so that the hold-until-grant and second-half stall paths are each driven.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int LSU_AW    = 32;
    localparam int LSU_DW    = 32;
    localparam int LSU_NB    = LSU_DW / 8;
    localparam int LSU_OW    = $clog2(LSU_NB);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic [LSU_AW-1:0] addr;
        logic [LSU_NB-1:0] be;
        logic [LSU_DW-1:0] wdata;
        logic              we;
    } bus_txn_t;

    typedef struct packed {
        acc_size_e         size;
        logic              uns;
        logic [LSU_OW-1:0] ofs;
        logic              split;
        logic              we;
    } wb_info_t;

    function automatic acc_size_e decode_size(input logic [1:0] raw);
        case (raw)
            2'd0:    return SZ_BYTE;
            2'd1:    return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic logic [LSU_NB-1:0] size_mask(input acc_size_e s);
        case (s)
            SZ_BYTE: return LSU_NB'(1);
            SZ_HALF: return LSU_NB'(3);
            default: return '1;
        endcase
    endfunction

    function automatic logic [LSU_DW-1:0] rotl_lanes(input logic [LSU_DW-1:0] d,
                                                      input logic [LSU_OW-1:0] o);
        logic [2*LSU_DW-1:0] t;
        t = {d, d} << {o, 3'b000};
        return t[2*LSU_DW-1:LSU_DW];
    endfunction

    function automatic logic [LSU_DW-1:0] extend_load(input logic [LSU_DW-1:0] d,
                                                       input acc_size_e s,
                                                       input logic uns);
        case (s)
            SZ_BYTE: return uns ? {{(LSU_DW-8){1'b0}}, d[7:0]}
                                : {{(LSU_DW-8){d[7]}}, d[7:0]};
            SZ_HALF: return uns ? {{(LSU_DW-16){1'b0}}, d[15:0]}
                                : {{(LSU_DW-16){d[15]}}, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/lsu_agu.sv
module lsu_agu
    import lsu_pkg::*;
(
    input  logic [LSU_AW-1:0] base_i,
    input  logic [LSU_AW-1:0] offset_i,
    input  logic [1:0]        size_i,
    input  logic              uns_i,
    input  logic              we_i,
    input  logic [LSU_DW-1:0] wdata_i,
    output bus_txn_t          first_o,
    output bus_txn_t          second_o,
    output logic              split_o,
    output wb_info_t          info_o
);

    logic [LSU_AW-1:0]   eff_addr;
    logic [LSU_AW-1:0]   word_addr;
    logic [LSU_OW-1:0]   ofs;
    acc_size_e           sz;
    logic [2*LSU_NB-1:0] lane_span;
    logic [LSU_DW-1:0]   rot_data;

    always_comb begin
        eff_addr  = base_i + offset_i;
        ofs       = eff_addr[LSU_OW-1:0];
        word_addr = {eff_addr[LSU_AW-1:LSU_OW], {LSU_OW{1'b0}}};
        sz        = decode_size(size_i);
        lane_span = {{LSU_NB{1'b0}}, size_mask(sz)} << ofs;
        rot_data  = rotl_lanes(wdata_i, ofs);
    end

    assign split_o = |lane_span[2*LSU_NB-1:LSU_NB];

    assign first_o = '{addr:  word_addr,
                       be:    lane_span[LSU_NB-1:0],
                       wdata: rot_data,
                       we:    we_i};

    assign second_o = '{addr:  word_addr + LSU_AW'(LSU_NB),
                        be:    lane_span[2*LSU_NB-1:LSU_NB],
                        wdata: rot_data,
                        we:    we_i};

    assign info_o = '{size: sz, uns: uns_i, ofs: ofs, split: split_o, we: we_i};

endmodule

// File: rtl/lsu_req_ctrl.sv
module lsu_req_ctrl
    import lsu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_valid_i,
    input  logic     split_i,
    input  bus_txn_t first_i,
    input  bus_txn_t second_i,
    input  logic     wb_free_i,
    input  logic     gnt_i,
    output logic     bus_req_o,
    output bus_txn_t bus_txn_o,
    output logic     accept_o,
    output logic     ex_second_o,
    output logic     ex_stall_o
);

    logic     second_q;
    bus_txn_t second_txn_q;
    logic     final_grant;

    always_comb begin
        if (second_q) begin
            bus_req_o   = !rst;
            bus_txn_o   = second_txn_q;
            final_grant = bus_req_o && gnt_i;
            accept_o    = 1'b0;
            ex_stall_o  = !final_grant;
        end else begin
            bus_req_o   = op_valid_i && wb_free_i && !rst;
            bus_txn_o   = first_i;
            final_grant = bus_req_o && gnt_i && !split_i;
            accept_o    = bus_req_o && gnt_i;
            ex_stall_o  = op_valid_i && !final_grant && !rst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q     <= 1'b0;
            second_txn_q <= '0;
        end else if (second_q) begin
            if (gnt_i) second_q <= 1'b0;
        end else if (accept_o && split_i) begin
            second_q     <= 1'b1;
            second_txn_q <= second_i;
        end
    end

    assign ex_second_o = second_q;

endmodule

// File: rtl/lsu_wb_merge.sv
module lsu_wb_merge
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  wb_info_t          info_i,
    input  logic              rvalid_i,
    input  logic [LSU_DW-1:0] rdata_i,
    output logic              busy_o,
    output logic              final_now_o,
    output logic              wb_valid_o,
    output logic [LSU_DW-1:0] wb_data_o
);

    logic              busy_q;
    logic              got_q;
    wb_info_t          info_q;
    logic [LSU_DW-1:0] low_q;
    logic [2*LSU_DW-1:0] joined;
    logic [2*LSU_DW-1:0] aligned;

    assign final_now_o = busy_q && rvalid_i && (!info_q.split || got_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            got_q  <= 1'b0;
            info_q <= '0;
            low_q  <= '0;
        end else begin
            if (final_now_o) busy_q <= 1'b0;
            if (busy_q && rvalid_i && !final_now_o) begin
                got_q <= 1'b1;
                low_q <= rdata_i;
            end
            if (accept_i) begin
                busy_q <= 1'b1;
                got_q  <= 1'b0;
                info_q <= info_i;
            end
        end
    end

    always_comb begin
        joined  = info_q.split ? {rdata_i, low_q} : {{LSU_DW{1'b0}}, rdata_i};
        aligned = joined >> {info_q.ofs, 3'b000};
    end

    assign busy_o     = busy_q;
    assign wb_valid_o = final_now_o && !info_q.we;
    assign wb_data_o  = extend_load(aligned[LSU_DW-1:0], info_q.size, info_q.uns);

endmodule

// File: rtl/lsu_split_unit.sv
module lsu_split_unit
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_valid_i,
    input  logic              ex_we_i,
    input  logic [1:0]        ex_size_i,
    input  logic              ex_unsigned_i,
    input  logic [LSU_AW-1:0] ex_base_i,
    input  logic [LSU_AW-1:0] ex_offset_i,
    input  logic [LSU_DW-1:0] ex_wdata_i,
    output logic              stall_o,
    output logic              dbus_req_o,
    output logic              dbus_we_o,
    output logic [LSU_AW-1:0] dbus_addr_o,
    output logic [LSU_NB-1:0] dbus_be_o,
    output logic [LSU_DW-1:0] dbus_wdata_o,
    input  logic              dbus_gnt_i,
    input  logic              dbus_rvalid_i,
    input  logic [LSU_DW-1:0] dbus_rdata_i,
    output logic              wb_valid_o,
    output logic [LSU_DW-1:0] wb_data_o
);

    bus_txn_t first_txn, second_txn, cur_txn;
    wb_info_t op_info;
    logic     op_split, accept, ex_second, ex_stall;
    logic     wb_busy, wb_final, wb_vld;

    lsu_agu u_agu (
        .base_i   (ex_base_i),
        .offset_i (ex_offset_i),
        .size_i   (ex_size_i),
        .uns_i    (ex_unsigned_i),
        .we_i     (ex_we_i),
        .wdata_i  (ex_wdata_i),
        .first_o  (first_txn),
        .second_o (second_txn),
        .split_o  (op_split),
        .info_o   (op_info)
    );

    lsu_req_ctrl u_req (
        .clk         (clk),
        .rst         (rst),
        .op_valid_i  (ex_valid_i),
        .split_i     (op_split),
        .first_i     (first_txn),
        .second_i    (second_txn),
        .wb_free_i   (!wb_busy || wb_final),
        .gnt_i       (dbus_gnt_i),
        .bus_req_o   (dbus_req_o),
        .bus_txn_o   (cur_txn),
        .accept_o    (accept),
        .ex_second_o (ex_second),
        .ex_stall_o  (ex_stall)
    );

    lsu_wb_merge u_wb (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .info_i      (op_info),
        .rvalid_i    (dbus_rvalid_i),
        .rdata_i     (dbus_rdata_i),
        .busy_o      (wb_busy),
        .final_now_o (wb_final),
        .wb_valid_o  (wb_vld),
        .wb_data_o   (wb_data_o)
    );

    assign dbus_we_o    = cur_txn.we;
    assign dbus_addr_o  = cur_txn.addr;
    assign dbus_be_o    = cur_txn.be;
    assign dbus_wdata_o = cur_txn.wdata;
    assign wb_valid_o   = wb_vld && !rst;
    assign stall_o      = !rst && (ex_stall || (wb_busy && !ex_second && !wb_final));

endmodule

// File: rtl/lsu_split_chk.sv
module lsu_split_chk (
    input logic        clk,
    input logic        rst,
    input logic        stall_o,
    input logic        dbus_req_o,
    input logic [31:0] dbus_addr_o,
    input logic [3:0]  dbus_be_o,
    input logic        dbus_gnt_i,
    input logic        dbus_rvalid_i,
    input logic        wb_valid_o
);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dbus_req_o && !dbus_gnt_i |=> dbus_req_o && $stable(dbus_addr_o) && $stable(dbus_be_o));

    // R1
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        dbus_req_o |-> (dbus_addr_o[1:0] == 2'b00) && (dbus_be_o != 4'b0000));

    // R4
    grant_stall_chk: assert property (@(posedge clk) disable iff (rst)
        dbus_req_o && !dbus_gnt_i |-> stall_o);

    // R9
    wb_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> dbus_rvalid_i);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !dbus_req_o && !stall_o && !wb_valid_o);

endmodule

bind lsu_split_unit lsu_split_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .stall_o       (stall_o),
    .dbus_req_o    (dbus_req_o),
    .dbus_addr_o   (dbus_addr_o),
    .dbus_be_o     (dbus_be_o),
    .dbus_gnt_i    (dbus_gnt_i),
    .dbus_rvalid_i (dbus_rvalid_i),
    .wb_valid_o    (wb_valid_o)
);

// File: tb/lsu_split_unit_tb.sv
`timescale 1ns/1ps
module lsu_split_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ex_valid = 1'b0, ex_we = 1'b0, ex_uns = 1'b0;
    logic [1:0]  ex_size = 2'd0;
    logic [31:0] ex_base = '0, ex_off = '0, ex_wdata = '0;
    logic        stall, dreq, dwe, dgnt, drvalid, wbv;
    logic [31:0] daddr, dwdata, drdata, wbd;
    logic [3:0]  dbe;

    always #10 clk = ~clk;

    lsu_split_unit u_dut (
        .clk(clk), .rst(rst), .ex_valid_i(ex_valid), .ex_we_i(ex_we),
        .ex_size_i(ex_size), .ex_unsigned_i(ex_uns), .ex_base_i(ex_base),
        .ex_offset_i(ex_off), .ex_wdata_i(ex_wdata), .stall_o(stall),
        .dbus_req_o(dreq), .dbus_we_o(dwe), .dbus_addr_o(daddr), .dbus_be_o(dbe),
        .dbus_wdata_o(dwdata), .dbus_gnt_i(dgnt), .dbus_rvalid_i(drvalid),
        .dbus_rdata_i(drdata), .wb_valid_o(wbv), .wb_data_o(wbd)
    );

    // ---------------- bus model ----------------
    logic [7:0]  mem_b [64];
    int          gw_cfg = 0, lat_cfg = 1, wait_cnt = 0;
    logic        p1_v = 1'b0, p2_v = 1'b0;
    logic [31:0] p1_d = '0, p2_d = '0;

    initial for (int a = 0; a < 64; a++) mem_b[a] = 8'(a * 37 + 5);

    assign dgnt    = dreq && (wait_cnt >= gw_cfg);
    assign drvalid = (lat_cfg == 2) ? p2_v : p1_v;
    assign drdata  = (lat_cfg == 2) ? p2_d : p1_d;

    always @(posedge clk) begin
        if (dreq && !dgnt) wait_cnt <= wait_cnt + 1;
        else               wait_cnt <= 0;
        p1_v <= dreq && dgnt;
        p1_d <= {mem_b[{daddr[5:2], 2'd3}], mem_b[{daddr[5:2], 2'd2}],
                 mem_b[{daddr[5:2], 2'd1}], mem_b[{daddr[5:2], 2'd0}]};
        p2_v <= p1_v;
        p2_d <= p1_d;
        if (dreq && dgnt && dwe)
            for (int k = 0; k < 4; k++)
                if (dbe[k]) mem_b[{daddr[5:2], 2'(k)}] <= dwdata[8*k +: 8];
    end

    // ---------------- monitor ----------------
    logic [31:0] tx_addr [4];
    logic [3:0]  tx_be   [4];
    logic [31:0] tx_wd   [4];
    logic        tx_we   [4];
    int          tx_n = 0;
    logic [31:0] wb_log  [4];
    int          wb_n = 0;

    always @(negedge clk) begin
        if (dreq && dgnt) begin
            if (tx_n < 4) begin
                tx_addr[tx_n] = daddr; tx_be[tx_n] = dbe;
                tx_wd[tx_n] = dwdata;  tx_we[tx_n] = dwe;
            end
            tx_n = tx_n + 1;
        end
        if (wbv) begin
            if (wb_n < 4) wb_log[wb_n] = wbd;
            wb_n = wb_n + 1;
        end
    end

    // ---------------- checking ----------------
    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(input logic [31:0] a, input logic [1:0] sz,
                                             input logic uns);
        logic [31:0] v = '0;
        int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int k = 0; k < n; k++) v[8*k +: 8] = mem_b[(a + 32'(k)) & 32'h3f];
        if (sz == 2'd0) v = uns ? {24'h0, v[7:0]}  : {{24{v[7]}}, v[7:0]};
        if (sz == 2'd1) v = uns ? {16'h0, v[15:0]} : {{16{v[15]}}, v[15:0]};
        return v;
    endfunction

    function automatic logic [31:0] ref_rot(input logic [31:0] d, input logic [1:0] o);
        logic [63:0] t = {d, d} << (8 * o);
        return t[63:32];
    endfunction

    typedef struct packed {
        logic        we;
        logic [1:0]  size;
        logic        uns;
        logic [31:0] addr;
        logic [31:0] off;
        logic [31:0] wdata;
        logic [2:0]  ntx;
        logic [3:0]  be0;
        logic [3:0]  be1;
        logic [1:0]  gw;
        logic [1:0]  lat;
    } vec_t;

    localparam vec_t TBL [16] = '{
        '{1'b0, 2'd2, 1'b0, 32'h10, 32'h0,        32'h0,        3'd1, 4'hF, 4'h0, 2'd0, 2'd1},
        '{1'b0, 2'd2, 1'b0, 32'h11, 32'h4,        32'h0,        3'd2, 4'hE, 4'h1, 2'd0, 2'd1},
        '{1'b0, 2'd2, 1'b0, 32'h12, 32'hFFFFFFF8, 32'h0,        3'd2, 4'hC, 4'h3, 2'd1, 2'd2},
        '{1'b0, 2'd2, 1'b0, 32'h13, 32'h0,        32'h0,        3'd2, 4'h8, 4'h7, 2'd2, 2'd1},
        '{1'b0, 2'd1, 1'b0, 32'h21, 32'h0,        32'h0,        3'd1, 4'h6, 4'h0, 2'd0, 2'd2},
        '{1'b0, 2'd1, 1'b0, 32'h23, 32'h1,        32'h0,        3'd2, 4'h8, 4'h1, 2'd0, 2'd1},
        '{1'b0, 2'd1, 1'b1, 32'h23, 32'h0,        32'h0,        3'd2, 4'h8, 4'h1, 2'd1, 2'd1},
        '{1'b0, 2'd0, 1'b0, 32'h14, 32'h0,        32'h0,        3'd1, 4'h1, 4'h0, 2'd0, 2'd1},
        '{1'b0, 2'd0, 1'b1, 32'h17, 32'h2,        32'h0,        3'd1, 4'h8, 4'h0, 2'd0, 2'd2},
        '{1'b1, 2'd2, 1'b0, 32'h31, 32'h0,        32'h11223344, 3'd2, 4'hE, 4'h1, 2'd1, 2'd1},
        '{1'b0, 2'd2, 1'b0, 32'h31, 32'hFFFFFFFC, 32'h0,        3'd2, 4'hE, 4'h1, 2'd0, 2'd1},
        '{1'b1, 2'd1, 1'b0, 32'h27, 32'h0,        32'hAAAA5566, 3'd2, 4'h8, 4'h1, 2'd0, 2'd2},
        '{1'b0, 2'd1, 1'b0, 32'h27, 32'h0,        32'h0,        3'd2, 4'h8, 4'h1, 2'd0, 2'd1},
        '{1'b1, 2'd0, 1'b0, 32'h3A, 32'h0,        32'h000000F0, 3'd1, 4'h4, 4'h0, 2'd0, 2'd1},
        '{1'b0, 2'd0, 1'b0, 32'h3A, 32'h0,        32'h0,        3'd1, 4'h4, 4'h0, 2'd0, 2'd1},
        '{1'b0, 2'd1, 1'b0, 32'h22, 32'h0,        32'h0,        3'd1, 4'hC, 4'h0, 2'd0, 2'd1}
    };

    task automatic run_vec(input vec_t v);
        logic [31:0] exp_ld, exp_wd, a0;
        int ex_st, post_st, exp_ex;
        exp_ld = ref_load(v.addr, v.size, v.uns);
        exp_wd = ref_rot(v.wdata, v.addr[1:0]);
        a0     = {v.addr[31:2], 2'b00};
        exp_ex = int'(v.ntx) * (1 + int'(v.gw)) - 1;
        gw_cfg = int'(v.gw); lat_cfg = int'(v.lat);
        @(posedge clk); #2;
        tx_n = 0; wb_n = 0;
        ex_valid = 1'b1; ex_we = v.we; ex_size = v.size; ex_uns = v.uns;
        ex_off = v.off; ex_base = v.addr - v.off; ex_wdata = v.wdata;
        ex_st = 0;
        @(negedge clk);
        while (stall && ex_st < 20) begin ex_st++; @(negedge clk); end
        @(posedge clk); #2;
        ex_valid = 1'b0;
        post_st = 0;
        repeat (5) begin @(negedge clk); if (stall) post_st++; end
        // R2 R3: transaction count decides splitting
        chk(tx_n == int'(v.ntx), "R2/R3 txn count", 32'(tx_n), 32'(v.ntx));
        // R1: first address and lanes
        chk(tx_addr[0] == a0, "R1 addr0", tx_addr[0], a0);
        chk(tx_be[0] == v.be0, "R1 be0", 32'(tx_be[0]), 32'(v.be0));
        if (v.ntx == 3'd2) begin
            // R2: second word and remaining lanes
            chk(tx_addr[1] == a0 + 32'd4, "R2 addr1", tx_addr[1], a0 + 32'd4);
            chk(tx_be[1] == v.be1, "R2 be1", 32'(tx_be[1]), 32'(v.be1));
        end
        // R4: execute-phase stall length
        chk(ex_st == exp_ex, "R4 ex stall cycles", 32'(ex_st), 32'(exp_ex));
        // R9: writeback wait stall
        chk(post_st == int'(v.lat) - 1, "R9 wb stall cycles", 32'(post_st), 32'(v.lat) - 1);
        if (v.we) begin
            // R6: rotated store data on each transaction
            chk(tx_wd[0] == exp_wd && tx_we[0], "R6 wdata0", tx_wd[0], exp_wd);
            if (v.ntx == 3'd2) chk(tx_wd[1] == exp_wd, "R6 wdata1", tx_wd[1], exp_wd);
            chk(wb_n == 0, "R9 no wb on store", 32'(wb_n), 32'd0);
        end else begin
            chk(wb_n == 1, "R9 one wb pulse", 32'(wb_n), 32'd1);
            // R7 R8: merged and extended result
            chk(wb_log[0] == exp_ld, "R7/R8 load data", wb_log[0], exp_ld);
        end
    endtask

    initial begin
        // R10: reset holds outputs quiet even with an access offered
        ex_valid = 1'b1; ex_size = 2'd2; ex_base = 32'h10;
        repeat (3) @(negedge clk);
        chk(!dreq, "R10 req in reset", 32'(dreq), 32'd0);
        chk(!stall, "R10 stall in reset", 32'(stall), 32'd0);
        chk(!wbv, "R10 wb_valid in reset", 32'(wbv), 32'd0);
        @(posedge clk); #2;
        rst = 1'b0; ex_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(!dreq && !stall, "R10 idle after reset", {30'd0, dreq, stall}, 32'd0);

        for (int i = 0; i < 16; i++) run_vec(TBL[i]);

        // R11: second load behind first with two-cycle response latency
        begin
            logic [31:0] ea, eb;
            ea = ref_load(32'h10, 2'd2, 1'b0);
            eb = ref_load(32'h18, 2'd2, 1'b0);
            gw_cfg = 0; lat_cfg = 2;
            @(posedge clk); #2;
            tx_n = 0; wb_n = 0;
            ex_valid = 1'b1; ex_we = 1'b0; ex_size = 2'd2; ex_uns = 1'b0;
            ex_off = 32'h0; ex_base = 32'h10;
            @(negedge clk);
            chk(!stall && dreq, "R11 first issues", {30'd0, stall, dreq}, 32'd1);
            @(posedge clk); #2;
            ex_base = 32'h18;
            @(negedge clk);
            chk(!dreq, "R11 held while wb waits", 32'(dreq), 32'd0);
            chk(stall, "R11 stall while wb waits", 32'(stall), 32'd1);
            @(negedge clk);
            chk(dreq && !stall, "R11 issue on response cycle", {30'd0, dreq, stall}, 32'd2);
            @(posedge clk); #2;
            ex_valid = 1'b0;
            repeat (5) @(negedge clk);
            chk(wb_n == 2, "R11 two results", 32'(wb_n), 32'd2);
            chk(wb_log[0] == ea, "R11 result A", wb_log[0], ea);
            chk(wb_log[1] == eb, "R11 result B", wb_log[1], eb);
        end

        // R5: request held through a long grant wait
        begin
            gw_cfg = 3; lat_cfg = 1;
            @(posedge clk); #2;
            tx_n = 0;
            ex_valid = 1'b1; ex_we = 1'b0; ex_size = 2'd1; ex_base = 32'h2D; ex_off = 0;
            @(negedge clk);
            chk(dreq && daddr == 32'h2C && dbe == 4'h6, "R5 first req", daddr, 32'h2C);
            @(negedge clk);
            chk(dreq && daddr == 32'h2C && dbe == 4'h6, "R5 req held", daddr, 32'h2C);
            while (stall) @(negedge clk);
            @(posedge clk); #2;
            ex_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk(tx_n == 1, "R5 single grant", 32'(tx_n), 32'd1);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule